// File: doc/BRIEF.md
# Digital PI Regulator Controller

This block is the synchronous control loop of a digital low-dropout regulator. On each sampling clock it can accept one output-voltage sample from a delay-line time-to-digital converter. The sample is a thermometer-coded word whose number of ones is proportional to the regulated voltage, at roughly 25 mV per code step. The controller reduces the sample to a binary code and subtracts that code from a programmable reference to form a signed error. A proportional-integral law turns the error into the number of pass switches that should conduct.

The proportional and integral gains are programmable powers of two. Each gain is applied as an arithmetic left shift, so the block needs no multiplier. The integrator is a signed accumulator that clamps at its representable limits. The control value is saturated to the switch range before it is decoded into a thermometer enable vector for the pass array. Because the switch count is computed rather than shifted, it can move by many switches in a single sample.

Samples arrive on a valid/ready stream. The controller never applies back-pressure outside reset: `smp_ready` is high whenever `rst` is low, and each cycle with both `smp_valid` and `smp_ready` high consumes one sample. While reset is high, `smp_ready` is low and no sample is taken. The reference and gain inputs are plain levels that are read in the cycle a sample is consumed.

Top module: `dldo_pi_ctrl`

## Requirements
- R1: The decoded voltage code is the total number of ones in `smp_therm`, wherever they stand, so that bubbles in the thermometer word do not distort the code.
- R2: The error for a consumed sample is `ref_code` minus the decoded code, as a signed value in the range -64 to +64.
- R3: On each consumed sample the accumulator gains the error shifted left by `ki_shift`. A zero error leaves the accumulator unchanged, so two consecutive zero-error samples leave `sw_count` unchanged.
- R4: The control value is the error shifted left by `kp_shift`, plus the updated accumulator. `sw_count` takes this value clamped to the range 0 to 64 at the clock edge that consumes the sample, which is one cycle of latency.
- R5: `sw_en` is a thermometer vector with exactly `sw_count` ones, filled from bit 0 upward.
- R6: A synchronous active-high reset clears the accumulator and drives `sw_count` and `sw_en` to zero at the next edge.
- R7: In a cycle without a consumed sample, `sw_count`, `sw_en` and the accumulator keep their values, whatever is on `smp_therm`, `ref_code` and the gain inputs.
- R8: The accumulator is 16 bits signed and clamps to the range -32768 to +32767 instead of wrapping.
- R9: `sw_count` can change by more than one switch from one consumed sample to the next.
- R10: `smp_ready` is low while `rst` is high and high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_code | input | 7 | Target voltage code, 0 to 64 |
| kp_shift | input | 4 | Proportional gain as a left-shift count |
| ki_shift | input | 4 | Integral gain as a left-shift count |
| smp_valid | input | 1 | A converter sample is present |
| smp_ready | output | 1 | Controller can consume a sample |
| smp_therm | input | 64 | Thermometer-coded voltage sample |
| sw_count | output | 7 | Number of pass switches turned on |
| sw_en | output | 64 | Thermometer enable vector for the pass array |

## Verification
The bench builds the block with its defaults: a 64-bit sample, a 16-bit accumulator and 4-bit shift counts. Shifts of up to 15 let a single full-scale error carry the accumulator past either clamp in one sample. This makes the clamp, and recovery from the clamped value, observable within a few samples. The 64-switch range is small enough that both ends of the output saturation, and jumps of tens of switches, come within a handful of directed samples.

// File: rtl/dldo_pi_pkg.sv
package dldo_pi_pkg;
  localparam int WIDE_W = 32;
  typedef logic signed [WIDE_W-1:0] wide_t;
endpackage

// File: rtl/therm_popcount.sv
module therm_popcount #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  therm_i,
  output logic [CW-1:0] count_o
);
  // Counting ones instead of locating the first zero tolerates bubbles.
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + CW'(therm_i[i]);
    end
  end
endmodule

// File: rtl/pi_law.sv
module pi_law
  import dldo_pi_pkg::*;
#(
  parameter int CW      = 7,
  parameter int ACC_W   = 16,
  parameter int SHW     = 4,
  parameter int OUT_MAX = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_i,
  input  logic signed [CW:0]   err_i,
  input  logic [SHW-1:0]       kp_i,
  input  logic [SHW-1:0]       ki_i,
  output logic [CW-1:0]        ctrl_o
);
  localparam wide_t ACC_MAX = wide_t'((64'sd1 <<< (ACC_W-1)) - 64'sd1);
  localparam wide_t ACC_MIN = -ACC_MAX - wide_t'(1);
  localparam wide_t U_MAX   = wide_t'(OUT_MAX);

  logic signed [ACC_W-1:0] acc_q, acc_n;
  logic [CW-1:0]           ctrl_q, ctrl_n;
  wide_t                   e_w, sum_w, u_w;

  always_comb begin
    e_w   = wide_t'(err_i);
    sum_w = wide_t'(acc_q) + (e_w <<< ki_i);
    if (sum_w > ACC_MAX)      acc_n = ACC_W'(ACC_MAX);
    else if (sum_w < ACC_MIN) acc_n = ACC_W'(ACC_MIN);
    else                      acc_n = sum_w[ACC_W-1:0];
    u_w = (e_w <<< kp_i) + wide_t'(acc_n);
    if (u_w < 0)          ctrl_n = '0;
    else if (u_w > U_MAX) ctrl_n = CW'(OUT_MAX);
    else                  ctrl_n = u_w[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      ctrl_q <= '0;
    end else if (upd_i) begin
      acc_q  <= acc_n;
      ctrl_q <= ctrl_n;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/switch_decoder.sv
module switch_decoder #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [CW-1:0] count_i,
  output logic [W-1:0]  en_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign en_o[i] = (count_i > CW'(i));
  end
endmodule

// File: rtl/dldo_pi_ctrl.sv
module dldo_pi_ctrl #(
  parameter int THERM_W = 64,
  parameter int ACC_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int CNT_W  = $clog2(THERM_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   ref_code,
  input  logic [SHIFT_W-1:0] kp_shift,
  input  logic [SHIFT_W-1:0] ki_shift,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [THERM_W-1:0] smp_therm,
  output logic [CNT_W-1:0]   sw_count,
  output logic [THERM_W-1:0] sw_en
);
  logic [CNT_W-1:0]        v_code;
  logic signed [CNT_W:0]   err;
  logic                    take;

  assign smp_ready = ~rst;
  assign take      = smp_valid & smp_ready;

  therm_popcount #(.W(THERM_W), .CW(CNT_W)) u_dec (
    .therm_i (smp_therm),
    .count_o (v_code)
  );

  assign err = $signed({1'b0, ref_code}) - $signed({1'b0, v_code});

  pi_law #(.CW(CNT_W), .ACC_W(ACC_W), .SHW(SHIFT_W), .OUT_MAX(THERM_W)) u_pi (
    .clk    (clk),
    .rst    (rst),
    .upd_i  (take),
    .err_i  (err),
    .kp_i   (kp_shift),
    .ki_i   (ki_shift),
    .ctrl_o (sw_count)
  );

  switch_decoder #(.W(THERM_W), .CW(CNT_W)) u_sw (
    .count_i (sw_count),
    .en_o    (sw_en)
  );
endmodule

// File: rtl/dldo_pi_chk.sv
module dldo_pi_chk #(
  parameter int W     = 64,
  parameter int CW    = 7,
  parameter int ACC_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic signed [CW:0]      err,
  input logic signed [ACC_W-1:0] acc,
  input logic [CW-1:0]           sw_count,
  input logic [W-1:0]            sw_en
);
  a_r3_zero_err_holds_acc: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready && err == 0) |=> $stable(acc));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    sw_count <= CW'(W));

  a_r5_en_matches_count: assert property (@(posedge clk) disable iff (rst)
    $countones(sw_en) == int'(sw_count));

  a_r5_en_contiguous: assert property (@(posedge clk) disable iff (rst)
    (sw_en & (sw_en + 1'b1)) == '0);

  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (sw_count == '0 && sw_en == '0 && acc == '0));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && smp_ready) |=> ($stable(sw_count) && $stable(acc)));

  a_r10_ready_in_reset: assert property (@(posedge clk)
    rst |-> !smp_ready);
endmodule

bind dldo_pi_ctrl dldo_pi_chk #(.W(THERM_W), .CW(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .err       (err),
  .acc       (u_pi.acc_q),
  .sw_count  (sw_count),
  .sw_en     (sw_en)
);

// File: tb/sim_dldo_pi_ctrl.sv
`timescale 1ns/1ps
module sim_dldo_pi_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  ref_code;
  logic [3:0]  kp_shift, ki_shift;
  logic        smp_valid;
  logic        smp_ready;
  logic [63:0] smp_therm;
  logic [6:0]  sw_count;
  logic [63:0] sw_en;

  int n_cmp = 0;
  int n_bad = 0;
  longint m_acc = 0;
  int     m_cnt = 0;

  always #5 clk = ~clk;

  dldo_pi_ctrl u0 (
    .clk(clk), .rst(rst), .ref_code(ref_code), .kp_shift(kp_shift),
    .ki_shift(ki_shift), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_therm(smp_therm), .sw_count(sw_count), .sw_en(sw_en)
  );

  function automatic logic [63:0] thermo(int n);
    logic [63:0] v = '0;
    for (int i = 0; i < 64; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check({req, " sw_count"}, sw_count, m_cnt);
    n_cmp++;
    if (sw_en !== thermo(m_cnt)) begin
      n_bad++;
      $display("FAIL %s sw_en: got %h expected %h", req, sw_en, thermo(m_cnt));
    end
  endtask

  // Model built from R1..R4 and R8.
  task automatic send(string req, logic [63:0] th, int rf, int kp, int ki);
    longint e, u;
    @(negedge clk);
    smp_therm = th; ref_code = 7'(rf); kp_shift = 4'(kp); ki_shift = 4'(ki);
    smp_valid = 1'b1;
    @(posedge clk); #1;
    e = longint'(rf) - longint'($countones(th));
    m_acc = m_acc + (e <<< ki);
    if (m_acc > 32767) m_acc = 32767;
    if (m_acc < -32768) m_acc = -32768;
    u = (e <<< kp) + m_acc;
    m_cnt = (u < 0) ? 0 : (u > 64) ? 64 : int'(u);
    check_outputs(req);
  endtask

  task automatic t_reset();
    rst = 1'b1; smp_valid = 1'b0; smp_therm = '0;
    ref_code = '0; kp_shift = '0; ki_shift = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 ready low in reset", smp_ready, 0);
    m_acc = 0; m_cnt = 0;
    check_outputs("R6 reset");
    @(negedge clk); rst = 1'b0;
    #1;
    check("R10 ready high after reset", smp_ready, 1);
  endtask

  task automatic t_step();
    // err +30, acc 30, count 60: jump of 60 switches in one sample.
    send("R4 R9 first step", thermo(10), 40, 0, 0);
    check("R9 jump size", sw_count, 60);
  endtask

  task automatic t_zero_err();
    send("R3 zero error 1", thermo(40), 40, 2, 0);
    send("R3 zero error 2", thermo(40), 40, 2, 0);
    check("R3 count steady", sw_count, 30);
  endtask

  task automatic t_bubble();
    // 32 ones scattered; first-zero position would give 2.
    send("R1 R2 bubbles", 64'h00FF_00FF_0F0F_3333, 40, 0, 0);
    check("R1 bubble count", sw_count, 46);
  endtask

  task automatic t_hold();
    @(negedge clk);
    smp_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      smp_therm = {2{32'hA5A5_0F0F ^ 32'(i)}};
      ref_code = 7'(i * 13); kp_shift = 4'(i); ki_shift = 4'(i + 3);
      @(posedge clk); #1;
      check_outputs("R7 idle hold");
      @(negedge clk);
    end
  endtask

  task automatic t_sat();
    send("R4 low saturation", '1, 0, 2, 0);
    check("R4 floor", sw_count, 0);
    send("R4 high saturation", '0, 64, 3, 0);
    check("R4 ceiling", sw_count, 64);
  endtask

  task automatic t_acc_clamp();
    send("R8 clamp high", '0, 64, 0, 10);
    send("R8 after clamp", '1, 62, 0, 14);
    send("R8 R3 hold after clamp", thermo(5), 5, 0, 0);
    check("R8 clamp visible", sw_count, 0);
    send("R8 recovery", '0, 10, 0, 0);
    check("R8 recovery value", sw_count, 19);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    smp_valid = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    m_acc = 0; m_cnt = 0;
    check_outputs("R6 reset mid-run");
    @(negedge clk); rst = 1'b0; smp_valid = 1'b0;
    send("R6 acc cleared", thermo(20), 25, 0, 0);
    check("R6 fresh acc", sw_count, 10);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_step();
    t_zero_err();
    t_bubble();
    t_hold();
    t_sat();
    t_acc_clamp();
    t_reset_mid();
    @(negedge clk); smp_valid = 1'b0;
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule